// File: doc/BRIEF.md
# Performance Event Combiner Counter

This block is one slice of a hardware performance monitor. It receives a bank of raw event-increment inputs, each a small unsigned count for the current cycle. Four programmable selectors each pick one of those inputs. The four picks are merged into a single increment by three programmable operators, which are OR, AND, XOR or ADD. The increment is added to a 64-bit counter on every cycle in which counting is allowed.

Software reaches the block through two register-style write ports and two registered read outputs. One port serves the configuration word and the other serves the counter. The configuration word holds the selectors, the operators, five privilege-mode inhibit bits and a sticky overflow flag. Counting is gated in three ways: by a global enable, by a per-counter inhibit input, and by the mode-inhibit bits compared against a 3-bit current-mode input. The overflow flag is set only when a hardware increment carries out of the 64-bit counter.

Top module: `perf_combine_counter`

## Requirements
- R1: After a synchronous reset, `cnt_q` reads zero. `cfg_q` also reads zero: all selectors are 0, every operator is OR (code 0), all inhibit bits are clear and the overflow flag is clear.
- R2: A `cfg_we` write stores the following fields, which read back through `cfg_q` on the next cycle:
  - selector 0 at bits 9:0, selector 1 at 19:10, selector 2 at 29:20 and selector 3 at 39:30;
  - mode-inhibit bits 62:58;
  - the overflow flag at bit 63.
  Bits 57:55 always read zero.
- R3: The operator fields are op0 at bits 44:40, op1 at 49:45 and op2 at 54:50. The legal codes are OR=0, AND=1, XOR=2 and ADD=4. A write that carries any other code in a field leaves that field unchanged, while the other fields of the same write still take effect.
- R4: Selector value k picks event input k, which is `evt_in[k*EVT_W +: EVT_W]`. A selector value of `NUM_EVENTS` or more picks a constant zero.
- R5: The increment is op2(op0(e0,e1), op1(e2,e3)), where eN is the event picked by selector N. The operands are zero-extended to EVT_W+2 bits, so ADD never wraps.
- R6: The counter adds the increment only when all of the following hold:
  - the increment is nonzero;
  - `global_en` is 1;
  - `cnt_inhibit` is 0;
  - the current mode is not inhibited.
  Otherwise the counter holds.
- R7: The mode codes on `cur_mode` and their inhibit bits are:
  - 0 = U, inhibited by bit 60;
  - 1 = S, inhibited by bit 61;
  - 3 = M, inhibited by bit 62;
  - 4 = VU, inhibited by bit 58;
  - 5 = VS, inhibited by bit 59.
  A mode whose bit is set does not count. Other mode codes match no inhibit bit.
- R8: A `cnt_we` write loads `cnt_wdata` on the next cycle and takes priority over a same-cycle hardware increment.
- R9: A carry out of bit 63 from an active hardware increment sets the overflow flag, and the flag then holds. A counter write, including one in a cycle whose increment would have carried, never sets the flag.
- R10: A configuration write sets the overflow flag to the written bit 63, even in a cycle in which a hardware overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_EVENTS*EVT_W | Packed raw event increments, event k at k*EVT_W |
| global_en | input | 1 | Global count enable |
| cnt_inhibit | input | 1 | Per-counter inhibit |
| cur_mode | input | 3 | Current privilege mode code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 64 | Configuration write data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write data |
| cfg_q | output | 64 | Configuration word |
| cnt_q | output | CNT_W | Counter value |

## Verification
The hardest situation to reach from the ports is a carry out of the 64-bit counter, because counting up to it from zero is out of reach. The stimulus loads the counter through the write port to a value a few counts below the wrap point, then opens the enable for exactly one cycle. Both priority corners reuse that position. In one, a counter write lands in the very cycle whose increment would carry. In the other, a configuration write clearing the flag lands in the carry cycle.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int SEL_W    = 10;
  localparam int NUM_SEL  = 4;
  localparam int OP_W     = 5;
  localparam int NUM_OP   = 3;
  localparam int INH_W    = 5;
  localparam int SEL_LSB  = 0;
  localparam int OP_LSB   = 40;
  localparam int RSV_LSB  = 55;
  localparam int INH_LSB  = 58;
  localparam int OVF_BIT  = 63;
  localparam int CFG_W    = 64;

  typedef enum logic [OP_W-1:0] {
    OP_OR  = 5'd0,
    OP_AND = 5'd1,
    OP_XOR = 5'd2,
    OP_ADD = 5'd4
  } comb_op_e;

  // inhibit vector index inside the 5-bit field (bit 0 = cfg bit 58)
  localparam int IDX_VU = 0;
  localparam int IDX_VS = 1;
  localparam int IDX_U  = 2;
  localparam int IDX_S  = 3;
  localparam int IDX_M  = 4;

  localparam logic [2:0] MODE_U  = 3'd0;
  localparam logic [2:0] MODE_S  = 3'd1;
  localparam logic [2:0] MODE_M  = 3'd3;
  localparam logic [2:0] MODE_VU = 3'd4;
  localparam logic [2:0] MODE_VS = 3'd5;

  function automatic logic op_legal(input logic [OP_W-1:0] code);
    return (code == OP_OR) || (code == OP_AND) || (code == OP_XOR) || (code == OP_ADD);
  endfunction
endpackage

// File: rtl/pcc_event_select.sv
module pcc_event_select
  import pcc_pkg::*;
#(
  parameter int NUM_EVENTS = 16,
  parameter int EVT_W      = 8
) (
  input  logic [NUM_EVENTS*EVT_W-1:0] evt_in,
  input  logic [NUM_SEL*SEL_W-1:0]    sel_flat,
  output logic [NUM_SEL*EVT_W-1:0]    pick_flat
);
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    logic [SEL_W-1:0] sel;
    logic [EVT_W-1:0] pick;
    assign sel = sel_flat[g*SEL_W +: SEL_W];
    always_comb begin
      pick = '0;
      for (int j = 0; j < NUM_EVENTS; j++) begin
        if (sel == SEL_W'(j)) pick = evt_in[j*EVT_W +: EVT_W];
      end
    end
    assign pick_flat[g*EVT_W +: EVT_W] = pick;
  end
endmodule

// File: rtl/pcc_op.sv
module pcc_op
  import pcc_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y
);
  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      OP_ADD:  y = a + b;
      default: y = a | b;
    endcase
  end
endmodule

// File: rtl/pcc_combine.sv
module pcc_combine
  import pcc_pkg::*;
#(
  parameter int EVT_W = 8,
  parameter int INC_W = EVT_W + 2
) (
  input  logic [NUM_SEL*EVT_W-1:0] pick_flat,
  input  logic [NUM_OP*OP_W-1:0]   op_flat,
  output logic [INC_W-1:0]         inc
);
  logic [INC_W-1:0] pair [2];

  for (genvar p = 0; p < 2; p++) begin : g_pair
    pcc_op #(.W(INC_W)) u_op (
      .op (op_flat[p*OP_W +: OP_W]),
      .a  (INC_W'(pick_flat[(2*p)*EVT_W +: EVT_W])),
      .b  (INC_W'(pick_flat[(2*p+1)*EVT_W +: EVT_W])),
      .y  (pair[p])
    );
  end

  pcc_op #(.W(INC_W)) u_final (
    .op (op_flat[2*OP_W +: OP_W]),
    .a  (pair[0]),
    .b  (pair[1]),
    .y  (inc)
  );
endmodule

// File: rtl/pcc_cfg_reg.sv
module pcc_cfg_reg
  import pcc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [CFG_W-1:0]        wdata,
  input  logic                    hw_ovf,
  output logic [NUM_SEL*SEL_W-1:0] sel_flat,
  output logic [NUM_OP*OP_W-1:0]  op_flat,
  output logic [INH_W-1:0]        inh,
  output logic [CFG_W-1:0]        cfg_q
);
  logic ovf_q;
  logic unused_rsvd;
  assign unused_rsvd = ^wdata[RSV_LSB +: 3];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_flat <= '0;
      inh      <= '0;
    end else if (we) begin
      sel_flat <= wdata[SEL_LSB +: NUM_SEL*SEL_W];
      inh      <= wdata[INH_LSB +: INH_W];
    end
  end

  for (genvar k = 0; k < NUM_OP; k++) begin : g_op
    logic [OP_W-1:0] op_new;
    assign op_new = wdata[OP_LSB + k*OP_W +: OP_W];
    always_ff @(posedge clk) begin
      if (rst) op_flat[k*OP_W +: OP_W] <= OP_OR;
      else if (we && op_legal(op_new)) op_flat[k*OP_W +: OP_W] <= op_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ovf_q <= 1'b0;
    else if (we)     ovf_q <= wdata[OVF_BIT];
    else if (hw_ovf) ovf_q <= 1'b1;
  end

  assign cfg_q = {ovf_q, inh, 3'b000, op_flat, sel_flat};
endmodule

// File: rtl/pcc_counter.sv
module pcc_counter #(
  parameter int CNT_W = 64,
  parameter int INC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             count_en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             carry
);
  localparam int EXT_W = CNT_W + 1;
  logic [EXT_W-1:0] sum;

  assign sum   = {1'b0, cnt_q} + EXT_W'(inc);
  assign carry = sum[CNT_W];

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (we)       cnt_q <= wdata;
    else if (count_en) cnt_q <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/perf_combine_counter.sv
module perf_combine_counter
  import pcc_pkg::*;
#(
  parameter int NUM_EVENTS = 16,
  parameter int EVT_W      = 8,
  parameter int CNT_W      = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_EVENTS*EVT_W-1:0] evt_in,
  input  logic                        global_en,
  input  logic                        cnt_inhibit,
  input  logic [2:0]                  cur_mode,
  input  logic                        cfg_we,
  input  logic [CFG_W-1:0]            cfg_wdata,
  input  logic                        cnt_we,
  input  logic [CNT_W-1:0]            cnt_wdata,
  output logic [CFG_W-1:0]            cfg_q,
  output logic [CNT_W-1:0]            cnt_q
);
  localparam int INC_W = EVT_W + 2;

  logic [NUM_SEL*SEL_W-1:0] sel_flat;
  logic [NUM_OP*OP_W-1:0]   op_flat;
  logic [INH_W-1:0]         inh;
  logic [NUM_SEL*EVT_W-1:0] pick_flat;
  logic [INC_W-1:0]         inc;
  logic                     mode_blocked;
  logic                     count_en;
  logic                     carry;
  logic                     hw_ovf;

  pcc_cfg_reg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .hw_ovf   (hw_ovf),
    .sel_flat (sel_flat),
    .op_flat  (op_flat),
    .inh      (inh),
    .cfg_q    (cfg_q)
  );

  pcc_event_select #(.NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W)) u_sel (
    .evt_in    (evt_in),
    .sel_flat  (sel_flat),
    .pick_flat (pick_flat)
  );

  pcc_combine #(.EVT_W(EVT_W), .INC_W(INC_W)) u_comb (
    .pick_flat (pick_flat),
    .op_flat   (op_flat),
    .inc       (inc)
  );

  always_comb begin
    case (cur_mode)
      MODE_U:  mode_blocked = inh[IDX_U];
      MODE_S:  mode_blocked = inh[IDX_S];
      MODE_M:  mode_blocked = inh[IDX_M];
      MODE_VU: mode_blocked = inh[IDX_VU];
      MODE_VS: mode_blocked = inh[IDX_VS];
      default: mode_blocked = 1'b0;
    endcase
  end

  assign count_en = global_en && !cnt_inhibit && !mode_blocked && (inc != '0);
  assign hw_ovf   = count_en && !cnt_we && carry;

  pcc_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .we       (cnt_we),
    .wdata    (cnt_wdata),
    .count_en (count_en),
    .inc      (inc),
    .cnt_q    (cnt_q),
    .carry    (carry)
  );
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker
  import pcc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             global_en,
  input logic             cnt_inhibit,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CFG_W-1:0] cfg_q,
  input logic [CNT_W-1:0] cnt_q
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && cfg_q == '0));

  p_ops_legal_r3: assert property (@(posedge clk) disable iff (rst)
    op_legal(cfg_q[OP_LSB +: OP_W]) && op_legal(cfg_q[OP_LSB+OP_W +: OP_W]) &&
    op_legal(cfg_q[OP_LSB+2*OP_W +: OP_W]));

  p_inhibit_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && (!global_en || cnt_inhibit)) |=> $stable(cnt_q));

  p_cnt_write_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_q == $past(cnt_wdata)));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && cfg_q[OVF_BIT]) |=> cfg_q[OVF_BIT]);

  p_no_sw_ovf_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !cfg_q[OVF_BIT] && (cnt_we || !global_en || cnt_inhibit)) |=> !cfg_q[OVF_BIT]);

  p_cfg_ovf_wins_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cfg_q[OVF_BIT] == $past(cfg_wdata[OVF_BIT])));
endmodule

bind perf_combine_counter pcc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .global_en   (global_en),
  .cnt_inhibit (cnt_inhibit),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .cnt_we      (cnt_we),
  .cnt_wdata   (cnt_wdata),
  .cfg_q       (cfg_q),
  .cnt_q       (cnt_q)
);

// File: tb/perf_combine_counter_tb.sv
`timescale 1ns/1ps
module perf_combine_counter_tb;
  localparam int NE = 16;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE*EW-1:0] evt_in;
  logic          global_en = 1'b0;
  logic          cnt_inhibit = 1'b0;
  logic [2:0]    cur_mode = 3'd0;
  logic          cfg_we = 1'b0;
  logic [63:0]   cfg_wdata = '0;
  logic          cnt_we = 1'b0;
  logic [63:0]   cnt_wdata = '0;
  logic [63:0]   cfg_q;
  logic [63:0]   cnt_q;

  logic [EW-1:0] ev [NE];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] exp_cnt;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NE; i++) evt_in[i*EW +: EW] = ev[i];
  end

  perf_combine_counter u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .global_en(global_en),
    .cnt_inhibit(cnt_inhibit), .cur_mode(cur_mode), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cfg_q(cfg_q), .cnt_q(cnt_q)
  );

  function automatic logic [63:0] mk_cfg(input int s0, s1, s2, s3, o0, o1, o2,
                                          input logic [4:0] inh, input logic ovf);
    return {ovf, inh, 3'b000, 5'(o2), 5'(o1), 5'(o0), 10'(s3), 10'(s2), 10'(s1), 10'(s0)};
  endfunction

  function automatic logic [9:0] pick(input logic [9:0] s);
    return (s < NE) ? 10'(ev[s[3:0]]) : 10'd0;
  endfunction

  function automatic logic [9:0] apply(input logic [4:0] op, input logic [9:0] a, b);
    case (op)
      5'd1: return a & b;
      5'd2: return a ^ b;
      5'd4: return a + b;
      default: return a | b;
    endcase
  endfunction

  function automatic logic [9:0] model_inc(input logic [63:0] c);
    logic [9:0] x, y;
    x = apply(c[44:40], pick(c[9:0]), pick(c[19:10]));
    y = apply(c[49:45], pick(c[29:20]), pick(c[39:30]));
    return apply(c[54:50], x, y);
  endfunction

  task automatic check64(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [63:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_cnt(input logic [63:0] w);
    cnt_we = 1'b1; cnt_wdata = w;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic count_once();
    global_en = 1'b1;
    @(negedge clk);
    global_en = 1'b0;
  endtask

  task automatic t_reset();
    check64("R1 cnt", cnt_q, 64'd0);
    check64("R1 cfg", cfg_q, 64'd0);
  endtask

  task automatic t_cfg_fields();
    logic [63:0] w;
    w = mk_cfg(5, 6, 7, 8, 0, 0, 0, 5'b10101, 1'b1);
    write_cfg(w | (64'h7 << 55));
    check64("R2 fields/rsvd", cfg_q, w);
    write_cfg(64'd0);
    check64("R2 clear", cfg_q, 64'd0);
  endtask

  task automatic t_ops();
    write_cfg(mk_cfg(0, 0, 0, 0, 1, 2, 4, 5'b0, 1'b0));
    check64("R3 legal ops", cfg_q, mk_cfg(0, 0, 0, 0, 1, 2, 4, 5'b0, 1'b0));
    write_cfg(mk_cfg(1, 0, 0, 0, 3, 8, 31, 5'b0, 1'b0));
    check64("R3 illegal kept", cfg_q, mk_cfg(1, 0, 0, 0, 1, 2, 4, 5'b0, 1'b0));
    write_cfg(mk_cfg(0, 0, 0, 0, 0, 4, 2, 5'b0, 1'b0));
    check64("R3 mixed legal", cfg_q, mk_cfg(0, 0, 0, 0, 0, 4, 2, 5'b0, 1'b0));
  endtask

  task automatic run_combo(input string req, input logic [63:0] c, input logic [63:0] inc_exp);
    write_cfg(c);
    check64({req, " model"}, 64'(model_inc(c)), inc_exp);
    count_once();
    exp_cnt = exp_cnt + inc_exp;
    check64(req, cnt_q, exp_cnt);
  endtask

  task automatic t_combine();
    exp_cnt = cnt_q;
    run_combo("R5 or/or/add",  mk_cfg(3, 7, 2, 15, 0, 0, 4, 5'b0, 1'b0), 64'h13E);
    run_combo("R5 and/xor/or", mk_cfg(3, 7, 2, 15, 1, 2, 0, 5'b0, 1'b0), 64'h00F);
    run_combo("R5 add/add/add", mk_cfg(3, 7, 2, 15, 4, 4, 4, 5'b0, 1'b0), 64'h233);
    run_combo("R4 out of range", mk_cfg(3, 20, 1023, 16, 4, 4, 4, 5'b0, 1'b0), 64'h035);
    run_combo("R5 xor/and/xor", mk_cfg(2, 2, 2, 7, 2, 1, 2, 5'b0, 1'b0), 64'h00F);
  endtask

  task automatic t_inhibit();
    write_cfg(mk_cfg(3, 1023, 1023, 1023, 4, 4, 4, 5'b0, 1'b0));
    exp_cnt = cnt_q;
    cnt_inhibit = 1'b1; count_once(); cnt_inhibit = 1'b0;
    check64("R6 cnt_inhibit", cnt_q, exp_cnt);
    @(negedge clk);
    check64("R6 global off", cnt_q, exp_cnt);
    write_cfg(mk_cfg(1023, 1023, 1023, 1023, 4, 4, 4, 5'b0, 1'b0));
    count_once();
    check64("R6 zero inc", cnt_q, exp_cnt);
    write_cfg(mk_cfg(3, 1023, 1023, 1023, 4, 4, 4, 5'b0, 1'b0));
    count_once();
    exp_cnt = exp_cnt + 64'h35;
    check64("R6 enabled", cnt_q, exp_cnt);
  endtask

  task automatic t_mode();
    write_cfg(mk_cfg(3, 1023, 1023, 1023, 4, 4, 4, 5'b11000, 1'b0));
    cur_mode = 3'd1; count_once();
    check64("R7 S inhibited", cnt_q, exp_cnt);
    cur_mode = 3'd3; count_once();
    check64("R7 M inhibited", cnt_q, exp_cnt);
    cur_mode = 3'd0; count_once();
    exp_cnt = exp_cnt + 64'h35;
    check64("R7 U counts", cnt_q, exp_cnt);
    write_cfg(mk_cfg(3, 1023, 1023, 1023, 4, 4, 4, 5'b00001, 1'b0));
    cur_mode = 3'd4; count_once();
    check64("R7 VU inhibited", cnt_q, exp_cnt);
    cur_mode = 3'd5; count_once();
    exp_cnt = exp_cnt + 64'h35;
    check64("R7 VS counts", cnt_q, exp_cnt);
    cur_mode = 3'd0;
    write_cfg(mk_cfg(3, 1023, 1023, 1023, 4, 4, 4, 5'b0, 1'b0));
  endtask

  task automatic t_sw_write();
    global_en = 1'b1;
    write_cnt(64'h1234_5678_9ABC_DEF0);
    global_en = 1'b0;
    check64("R8 write wins", cnt_q, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_overflow();
    write_cnt(64'hFFFF_FFFF_FFFF_FFFE);
    check64("R9 no flag on sw write", {63'd0, cfg_q[63]}, 64'd0);
    global_en = 1'b1;
    write_cnt(64'd5);
    global_en = 1'b0;
    check64("R9 write in carry cycle cnt", cnt_q, 64'd5);
    check64("R9 write in carry cycle flag", {63'd0, cfg_q[63]}, 64'd0);
    write_cnt(64'hFFFF_FFFF_FFFF_FFFE);
    count_once();
    check64("R9 wrap value", cnt_q, 64'h33);
    check64("R9 flag set", {63'd0, cfg_q[63]}, 64'd1);
    count_once();
    check64("R9 flag sticky", {63'd0, cfg_q[63]}, 64'd1);
    check64("R9 count after", cnt_q, 64'h68);
  endtask

  task automatic t_priority();
    write_cnt(64'hFFFF_FFFF_FFFF_FFF0);
    global_en = 1'b1;
    write_cfg(mk_cfg(3, 1023, 1023, 1023, 4, 4, 4, 5'b0, 1'b0));
    global_en = 1'b0;
    check64("R10 carry cycle cnt", cnt_q, 64'h25);
    check64("R10 write clears flag", {63'd0, cfg_q[63]}, 64'd0);
    count_once();
    check64("R10 stays clear", {63'd0, cfg_q[63]}, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) ev[i] = 8'(i * 3 + 1);
    ev[2] = 8'hFF; ev[3] = 8'h35; ev[7] = 8'h0F; ev[15] = 8'hF0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cfg_fields();
    t_ops();
    t_combine();
    t_inhibit();
    t_mode();
    t_sw_write();
    t_overflow();
    t_priority();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule